// File: doc/BRIEF.md
# Controller Data Memory with Pointer Windows

This block is the data memory of a small 8-bit controller. It stores two memory-pointer bytes and a 64-byte general-purpose RAM at addresses 20H to 5FH. It also decodes the special-register region at 04H to 1FH. Special registers that belong to neighbouring blocks are not stored here. Their values come in on pass-through inputs, and writes to them go out on pass-through outputs. Two addresses, 00H and 02H, are windows. An access to a window reaches the location whose address is held in the pointer at 01H or at 03H.

The block has one combinational read port and one write port. A write carries an address, a data byte, an operation code and a bit index. The operation either replaces the whole byte or sets or clears one bit. A bit operation is a read-modify-write of the current value, it completes in one clock, and it works through the windows as well. Writes to read-only special registers, to unimplemented addresses and to addresses above 5FH are dropped. Reads of unimplemented addresses and of addresses above 5FH return 00H.

Top module: `ctl_dmem`

## Requirements
- R1: After reset both pointer registers (01H and 03H) read 00H, so both windows (00H and 02H) then read 00H.
- R2: Addresses 20H to 5FH are read/write RAM. rd_data shows the stored byte in the same cycle as rd_addr, and a write becomes visible from the next cycle.
- R3: An access to address 00H (read, byte write or bit operation) reaches the location named by the pointer at 01H.
- R4: An access to address 02H reaches the location named by the pointer at 03H.
- R5: When the selected pointer holds 00H or 02H, the window reads 00H and writes through it have no effect.
- R6: wr_op 01 sets bit wr_bit of the target and wr_op 10 clears it. The other seven bits keep their value and the change takes one cycle. wr_op 00 writes the whole byte.
- R7: wr_op 11 changes nothing at any address.
- R8: Implemented special addresses read from ext_rdata, with ext_raddr naming the target. A write to one of them raises ext_we for one cycle, with ext_waddr naming the target and ext_wdata carrying the new byte. A bit operation on one of them starts from ext_wold. By default the implemented addresses are 04H to 0BH, 0DH, 0EH, 12H, 14H and 1EH.
- R9: Read-only special registers (by default 08H) ignore writes, and ext_we stays low for them.
- R10: Unimplemented special addresses and addresses 60H to FFH read 00H and ignore writes.
- R11: A read and a write that reach the same location in the same cycle return the old value, and the new value is read from the next cycle. This includes a pointer being rewritten while its window is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write byte |
| wr_op | input | 2 | 00 byte, 01 set bit, 10 clear bit, 11 none |
| wr_bit | input | 3 | Bit index for set/clear |
| ext_raddr | output | 8 | Resolved read address toward the special registers |
| ext_rdata | input | 8 | Value of the special register at ext_raddr |
| ext_waddr | output | 8 | Resolved write address toward the special registers |
| ext_wold | input | 8 | Current value of the special register at ext_waddr |
| ext_we | output | 1 | Write strobe for a special register |
| ext_wdata | output | 8 | New byte for the special register |

## Verification
The read port and the write port can reach the same location in one cycle. This can happen directly, when one port goes through a window and the other names the target itself, or when a pointer is rewritten while its window is read. Directed cases set up each of these collisions. The random phase picks addresses and pointer values with a bias toward 00H to 03H, the two window targets 00H and 02H, RAM and special registers, so collisions recur. A bench model resolves both ports from the state before the clock edge. It expects the read to return the old value, and it expects the write's effect on the following cycle.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int SFR_N  = 32;
  localparam int SFR_IW = $clog2(SFR_N);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t WIN0_A = 8'h00;
  localparam addr_t PTR0_A = 8'h01;
  localparam addr_t WIN1_A = 8'h02;
  localparam addr_t PTR1_A = 8'h03;
  localparam addr_t SFR_LO = 8'h04;
  localparam addr_t SFR_HI = 8'h1F;

  typedef enum logic [1:0] {
    OP_BYTE = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_NONE = 2'b11
  } wr_op_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PTR0,
    RG_PTR1,
    RG_SFR,
    RG_RAM
  } region_e;
endpackage

// File: rtl/dm_resolve.sv
module dm_resolve
  import dm_pkg::*;
#(
  parameter addr_t            RAM_LO   = 8'h20,
  parameter addr_t            RAM_HI   = 8'h5F,
  parameter logic [SFR_N-1:0] SFR_IMPL = 32'h4014_6FF0
) (
  input  addr_t   addr,
  input  addr_t   ptr0,
  input  addr_t   ptr1,
  output addr_t   eff,
  output region_e region
);
  logic through;
  logic dead;

  always_comb begin
    through = 1'b0;
    eff     = addr;
    if (addr == WIN0_A) begin
      through = 1'b1;
      eff     = ptr0;
    end else if (addr == WIN1_A) begin
      through = 1'b1;
      eff     = ptr1;
    end
    dead = through && (eff == WIN0_A || eff == WIN1_A);
    if (dead)
      region = RG_NONE;
    else if (eff == PTR0_A)
      region = RG_PTR0;
    else if (eff == PTR1_A)
      region = RG_PTR1;
    else if (eff >= SFR_LO && eff <= SFR_HI)
      region = SFR_IMPL[eff[SFR_IW-1:0]] ? RG_SFR : RG_NONE;
    else if (eff >= RAM_LO && eff <= RAM_HI)
      region = RG_RAM;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/dm_bitop.sv
module dm_bitop
  import dm_pkg::*;
(
  input  wr_op_e           op,
  input  data_t            old,
  input  data_t            wdata,
  input  logic [BIT_W-1:0] bidx,
  output data_t            result,
  output logic             apply
);
  data_t mask;

  always_comb begin
    mask  = data_t'(1) << bidx;
    apply = (op != OP_NONE);
    case (op)
      OP_SET:  result = old | mask;
      OP_CLR:  result = old & ~mask;
      OP_BYTE: result = wdata;
      default: result = old;
    endcase
  end
endmodule

// File: rtl/dm_store.sv
module dm_store
  import dm_pkg::*;
#(
  parameter addr_t RAM_LO = 8'h20,
  parameter addr_t RAM_HI = 8'h5F,
  localparam int   RAM_DEPTH = int'(RAM_HI) - int'(RAM_LO) + 1,
  localparam int   IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ptr_we,
  input  logic                  ram_we,
  input  logic [IDX_W-1:0]      w_idx,
  input  data_t                 wdata,
  input  logic [1:0][IDX_W-1:0] r_idx,
  output logic [1:0][DATA_W-1:0] ptr_q,
  output logic [1:0][DATA_W-1:0] ram_q
);
  data_t mem [RAM_DEPTH];
  logic [1:0][DATA_W-1:0] ptr_d;

  always_comb begin
    for (int i = 0; i < 2; i++)
      ptr_d[i] = ptr_we[i] ? wdata : ptr_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else
      ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (ram_we)
      mem[w_idx] <= wdata;
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      ram_q[i] = mem[r_idx[i]];
  end

  // R2
  ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> mem[$past(w_idx)] == $past(wdata));

  // R3
  ptr0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we[0] |=> ptr_q[0] == $past(wdata));

  // R4
  ptr1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we[1] |=> ptr_q[1] == $past(wdata));
endmodule

// File: rtl/ctl_dmem.sv
module ctl_dmem
  import dm_pkg::*;
#(
  parameter addr_t            RAM_LO   = 8'h20,
  parameter addr_t            RAM_HI   = 8'h5F,
  parameter logic [SFR_N-1:0] SFR_IMPL = 32'h4014_6FF0,
  parameter logic [SFR_N-1:0] SFR_RO   = 32'h0000_0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] wr_op,
  input  logic [2:0] wr_bit,
  output logic [7:0] ext_raddr,
  input  logic [7:0] ext_rdata,
  output logic [7:0] ext_waddr,
  input  logic [7:0] ext_wold,
  output logic       ext_we,
  output logic [7:0] ext_wdata
);
  localparam int RAM_DEPTH = int'(RAM_HI) - int'(RAM_LO) + 1;
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsync_q <= 2'b00;
    else
      rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  addr_t   port_addr [2];
  addr_t   eff       [2];
  region_e region    [2];
  data_t   ext_val   [2];
  data_t   val       [2];
  logic [1:0][IDX_W-1:0]  ram_idx;
  logic [1:0][DATA_W-1:0] ptr_q;
  logic [1:0][DATA_W-1:0] ram_q;

  assign port_addr[0] = rd_addr;
  assign port_addr[1] = wr_addr;
  assign ext_val[0]   = ext_rdata;
  assign ext_val[1]   = ext_wold;

  for (genvar p = 0; p < 2; p++) begin : g_port
    dm_resolve #(
      .RAM_LO  (RAM_LO),
      .RAM_HI  (RAM_HI),
      .SFR_IMPL(SFR_IMPL)
    ) u_res (
      .addr  (port_addr[p]),
      .ptr0  (ptr_q[0]),
      .ptr1  (ptr_q[1]),
      .eff   (eff[p]),
      .region(region[p])
    );

    assign ram_idx[p] = IDX_W'(eff[p] - RAM_LO);

    always_comb begin
      case (region[p])
        RG_PTR0: val[p] = ptr_q[0];
        RG_PTR1: val[p] = ptr_q[1];
        RG_SFR:  val[p] = ext_val[p];
        RG_RAM:  val[p] = ram_q[p];
        default: val[p] = '0;
      endcase
    end
  end

  wr_op_e op_e;
  data_t  new_val;
  logic   op_apply;
  logic   wr_ok;

  assign op_e = wr_op_e'(wr_op);

  dm_bitop u_bit (
    .op    (op_e),
    .old   (val[1]),
    .wdata (wr_data),
    .bidx  (wr_bit),
    .result(new_val),
    .apply (op_apply)
  );

  always_comb begin
    wr_ok = wr_en && op_apply && (region[1] != RG_NONE);
    if (region[1] == RG_SFR && SFR_RO[eff[1][SFR_IW-1:0]])
      wr_ok = 1'b0;
  end

  dm_store #(
    .RAM_LO(RAM_LO),
    .RAM_HI(RAM_HI)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ptr_we({wr_ok && region[1] == RG_PTR1, wr_ok && region[1] == RG_PTR0}),
    .ram_we(wr_ok && region[1] == RG_RAM),
    .w_idx (ram_idx[1]),
    .wdata (new_val),
    .r_idx (ram_idx),
    .ptr_q (ptr_q),
    .ram_q (ram_q)
  );

  assign rd_data   = val[0];
  assign ext_raddr = eff[0];
  assign ext_waddr = eff[1];
  assign ext_we    = wr_ok && (region[1] == RG_SFR);
  assign ext_wdata = new_val;

  // R10
  oob_read_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_addr > RAM_HI) |-> rd_data == 8'h00);

  // R5
  dead_win_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_addr == WIN0_A && (ptr_q[0] == WIN0_A || ptr_q[0] == WIN1_A)) |-> rd_data == 8'h00);

  // R8
  ext_range_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ext_we |-> (ext_waddr >= SFR_LO && ext_waddr <= SFR_HI));

  // R6
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ext_we && wr_op == 2'b01) |->
      (ext_wdata[wr_bit] && (((ext_wdata ^ ext_wold) & ~(8'h01 << wr_bit)) == 8'h00)));

  // R7
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_op == 2'b11) |-> !ext_we);
endmodule

// File: tb/sim_ctl_dmem.sv
module sim_ctl_dmem;
  localparam logic [31:0] IMPL = 32'h4014_6FF0;
  localparam logic [31:0] RO   = 32'h0000_0100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic       wr_en;
  logic [1:0] wr_op;
  logic [2:0] wr_bit;
  logic [7:0] ext_raddr, ext_rdata, ext_waddr, ext_wold, ext_wdata;
  logic       ext_we;

  logic [7:0] ram_m [64];
  logic [7:0] sfr_m [32];
  logic [7:0] p0_m, p1_m;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign ext_rdata = sfr_m[ext_raddr[4:0]];
  assign ext_wold  = sfr_m[ext_waddr[4:0]];

  ctl_dmem u0 (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_op(wr_op),
    .wr_bit(wr_bit), .ext_raddr(ext_raddr), .ext_rdata(ext_rdata),
    .ext_waddr(ext_waddr), .ext_wold(ext_wold), .ext_we(ext_we),
    .ext_wdata(ext_wdata)
  );

  function automatic logic [7:0] m_eff(input logic [7:0] a);
    if (a == 8'h00) return p0_m;
    if (a == 8'h02) return p1_m;
    return a;
  endfunction

  // 0 none, 1 pointer0, 2 pointer1, 3 special, 4 ram
  function automatic int m_reg(input logic [7:0] a);
    logic [7:0] e;
    e = m_eff(a);
    if ((a == 8'h00 || a == 8'h02) && (e == 8'h00 || e == 8'h02)) return 0;
    if (e == 8'h01) return 1;
    if (e == 8'h03) return 2;
    if (e >= 8'h04 && e <= 8'h1F) return IMPL[e[4:0]] ? 3 : 0;
    if (e >= 8'h20 && e <= 8'h5F) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] m_get(input logic [7:0] a);
    logic [7:0] e;
    e = m_eff(a);
    case (m_reg(a))
      1: return p0_m;
      2: return p1_m;
      3: return sfr_m[e[4:0]];
      4: return ram_m[e - 8'h20];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    if (m_reg(a) == 0 && (a == 8'h00 || a == 8'h02)) return "R5";
    if (a == 8'h00 || a == 8'h01) return "R3";
    if (a == 8'h02 || a == 8'h03) return "R4";
    if (a < 8'h20) return (m_reg(a) == 3) ? "R8" : "R10";
    if (a <= 8'h5F) return "R2";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [7:0] ra, input logic we,
                     input logic [7:0] wa, input logic [7:0] wd,
                     input logic [1:0] op, input logic [2:0] bi);
    logic [7:0] old, nv, e;
    logic ok, xw;
    int rg;
    string t;
    @(negedge clk);
    rd_addr = ra; wr_en = we; wr_addr = wa; wr_data = wd; wr_op = op; wr_bit = bi;
    #1;
    t = (tag == "") ? tag_for(ra) : tag;
    check(t, rd_data, m_get(ra));
    rg  = m_reg(wa);
    e   = m_eff(wa);
    old = m_get(wa);
    case (op)
      2'b01:   nv = old | (8'h01 << bi);
      2'b10:   nv = old & ~(8'h01 << bi);
      default: nv = wd;
    endcase
    ok = we && op != 2'b11 && rg != 0 && !(rg == 3 && RO[e[4:0]]);
    xw = ok && rg == 3;
    t = (tag == "") ? "R8" : tag;
    check(t, {7'd0, ext_we}, {7'd0, xw});
    if (xw) begin
      check(t, ext_waddr, e);
      check(t, ext_wdata, nv);
    end
    @(posedge clk);
    if (ok) begin
      case (rg)
        1: p0_m = nv;
        2: p1_m = nv;
        3: sfr_m[e[4:0]] = nv;
        default: ram_m[e - 8'h20] = nv;
      endcase
    end
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 8)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h01;
      3: return 8'h03;
      4: return 8'h04 + 8'($urandom % 28);
      5, 6: return 8'h20 + 8'($urandom % 64);
      default: return 8'h60 + 8'($urandom % 160);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    for (int i = 0; i < 32; i++) sfr_m[i] = 8'($urandom);
    for (int i = 0; i < 64; i++) ram_m[i] = 8'h00;
    p0_m = 8'h00; p1_m = 8'h00;
    rst_n = 1'b0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0; wr_op = 0; wr_bit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state of pointers and windows
    cyc("R1", 8'h01, 0, 8'h00, 8'h00, 2'b00, 3'd0);
    cyc("R1", 8'h03, 0, 8'h00, 8'h00, 2'b00, 3'd0);
    cyc("R1", 8'h00, 0, 8'h00, 8'h00, 2'b00, 3'd0);
    cyc("R1", 8'h02, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R2 fill RAM directly, reading back the previous location
    for (int i = 0; i < 64; i++)
      cyc("", (i == 0) ? 8'h20 : 8'(8'h1F + i), 1, 8'(8'h20 + i), 8'($urandom), 2'b00, 3'd0);
    cyc("R2", 8'h5F, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R3 window 0
    cyc("R3", 8'h00, 1, 8'h01, 8'h25, 2'b00, 3'd0);
    cyc("R3", 8'h00, 1, 8'h00, 8'hA5, 2'b00, 3'd0);
    cyc("R3", 8'h25, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R4 window 1 aimed at a special register
    cyc("R4", 8'h03, 1, 8'h03, 8'h0B, 2'b00, 3'd0);
    cyc("R4", 8'h02, 1, 8'h02, 8'h3C, 2'b00, 3'd0);
    cyc("R4", 8'h0B, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R5 dead windows
    cyc("R5", 8'h00, 1, 8'h01, 8'h02, 2'b00, 3'd0);
    cyc("R5", 8'h00, 1, 8'h00, 8'hFF, 2'b00, 3'd0);
    cyc("R5", 8'h0B, 1, 8'h00, 8'h00, 2'b01, 3'd7);
    cyc("R5", 8'h02, 1, 8'h01, 8'h00, 2'b00, 3'd0);
    cyc("R5", 8'h00, 1, 8'h00, 8'h77, 2'b00, 3'd0);

    // R6 bit operations through windows and direct
    cyc("R6", 8'h01, 1, 8'h01, 8'h30, 2'b00, 3'd0);
    cyc("R6", 8'h30, 1, 8'h00, 8'h00, 2'b01, 3'd3);
    cyc("R6", 8'h30, 1, 8'h30, 8'hFF, 2'b10, 3'd0);
    cyc("R6", 8'h30, 1, 8'h02, 8'h00, 2'b01, 3'd6);
    cyc("R6", 8'h0B, 1, 8'h02, 8'h00, 2'b10, 3'd2);
    cyc("R6", 8'h0B, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R7 no-op code
    cyc("R7", 8'h21, 1, 8'h21, 8'h5A, 2'b11, 3'd1);
    cyc("R7", 8'h21, 1, 8'h05, 8'h5A, 2'b11, 3'd1);
    cyc("R7", 8'h05, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R9 read-only register
    cyc("R9", 8'h08, 1, 8'h08, 8'h55, 2'b00, 3'd0);
    cyc("R9", 8'h08, 1, 8'h08, 8'h00, 2'b01, 3'd4);
    cyc("R9", 8'h08, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R10 unimplemented and high addresses
    cyc("R10", 8'h60, 1, 8'h60, 8'h99, 2'b00, 3'd0);
    cyc("R10", 8'h60, 1, 8'h1C, 8'h99, 2'b00, 3'd0);
    cyc("R10", 8'h1C, 1, 8'hFF, 8'h11, 2'b01, 3'd0);
    cyc("R10", 8'hFF, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // R11 same-cycle read and write of one location
    cyc("R11", 8'h25, 1, 8'h25, 8'hC3, 2'b00, 3'd0);
    cyc("R11", 8'h25, 0, 8'h00, 8'h00, 2'b00, 3'd0);
    cyc("R11", 8'h00, 1, 8'h01, 8'h40, 2'b00, 3'd0);
    cyc("R11", 8'h00, 1, 8'h40, 8'h0F, 2'b00, 3'd0);
    cyc("R11", 8'h00, 0, 8'h00, 8'h00, 2'b00, 3'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] wa, wd;
      wa = pick();
      wd = (wa == 8'h01 || wa == 8'h03) ? pick() : 8'($urandom);
      cyc("", pick(), ($urandom % 5) != 0, wa, wd, 2'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule